// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of seconds behind a small synchronous register interface. An external one-hertz enable, `tick_en`, advances the count by one on each clock cycle in which it is high. Software can read the count, load a new starting value, and program a match value. When the count arrives at the match value, a sticky alarm flag is set. The flag drives a single interrupt line through a one-bit mask, and a write to a dedicated clear register removes it.

The block decodes a 4 KB register window. All registers are word-aligned. Bus writes take effect on the clock edge at which `bus_wr` is sampled high. Read data is registered: it appears on `bus_rdata` one cycle after `bus_rd` is sampled high, and it holds until the next read. The top eight words of the window return fixed identification bytes.

Top module: `secs_alarm_rtc`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears the count, match, load, mask and raw status registers to zero. `irq_o` is low after reset.
- R2: Each cycle with `tick_en` high and no load write advances the count by one. The count wraps from 0xFFFFFFFF to 0. Without a tick or a load, the count holds.
- R3: A write to offset 0x08 sets the count to the written data. The load takes priority over a tick in the same cycle. A read of 0x08 returns the last value written there.
- R4: A read of offset 0x00 returns the count. A read of 0x04 returns the stored match value. The data appears on `bus_rdata` one cycle after `bus_rd`.
- R5: Raw status (offset 0x14, bit 0, upper bits zero) is set at the same edge at which the count becomes equal to the match value, whether by a tick or by a load. It then stays set until it is cleared.
- R6: A match value below the current count fires after the count wraps through zero.
- R7: `irq_o`, and reads of offset 0x18 bit 0, equal raw status ANDed with the mask (offset 0x10, bit 0 of the write data).
- R8: Any write to offset 0x1C clears raw status, whatever the data. A read of 0x1C returns zero.
- R9: If a clear write and a new match occur in the same cycle, raw status remains set.
- R10: A read of offset 0x0C returns 1. Writes to 0x0C have no effect.
- R11: Reads from 0xFE0 through 0xFFC return, in ascending word order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The word index is (offset − 0xFE0) >> 2.
- R12: Reads of undefined offsets return zero. Writes to undefined, read-only or identification offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-hertz advance enable, one cycle wide |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
The alarm is driven in four ways:
- a count that ticks up to a match above it;
- a match placed below the count, so the count must wrap through zero;
- a load that lands exactly on the match value;
- a tick-driven match in the same cycle as a clear write.

Together these separate a true equality test from a magnitude test, a load path from a tick path, and correct precedence from a clear that wins. The mask is toggled while raw status is held, which shows that the output gating does not disturb the sticky flag. Writes to the control, count, identification and undefined offsets are followed by reads, to show that nothing changed.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int ID_N = 8;
    localparam int ID_IW = $clog2(ID_N);

    localparam logic [AW-1:0] OFF_COUNT = AW'('h000);
    localparam logic [AW-1:0] OFF_MATCH = AW'('h004);
    localparam logic [AW-1:0] OFF_LOAD  = AW'('h008);
    localparam logic [AW-1:0] OFF_CTRL  = AW'('h00C);
    localparam logic [AW-1:0] OFF_MASK  = AW'('h010);
    localparam logic [AW-1:0] OFF_RAW   = AW'('h014);
    localparam logic [AW-1:0] OFF_MSKD  = AW'('h018);
    localparam logic [AW-1:0] OFF_CLR   = AW'('h01C);
    localparam logic [AW-1:0] OFF_ID    = AW'('hFE0);

    typedef enum logic [3:0] {
        SEL_COUNT, SEL_MATCH, SEL_LOAD, SEL_CTRL,
        SEL_MASK,  SEL_RAW,   SEL_MSKD, SEL_CLR,
        SEL_ID,    SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [ID_IW-1:0] id_idx;
        logic [DW-1:0]    wdata;
    } bus_cmd_t;

    function automatic logic [AW-1:0] word_of(input logic [AW-1:0] a);
        return {a[AW-1:2], 2'b00};
    endfunction

    function automatic reg_sel_e decode_sel(input logic [AW-1:0] a);
        logic [AW-1:0] w;
        w = word_of(a);
        if (w >= OFF_ID) return SEL_ID;
        case (w)
            OFF_COUNT: return SEL_COUNT;
            OFF_MATCH: return SEL_MATCH;
            OFF_LOAD:  return SEL_LOAD;
            OFF_CTRL:  return SEL_CTRL;
            OFF_MASK:  return SEL_MASK;
            OFF_RAW:   return SEL_RAW;
            OFF_MSKD:  return SEL_MSKD;
            OFF_CLR:   return SEL_CLR;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/sa_counter.sv
module sa_counter #(
    parameter int W = secs_alarm_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         cnt_adv,
    output logic [W-1:0] load_q
);

    always_comb begin
        cnt_adv = load_wr | tick_en;
        if (load_wr)
            cnt_nxt = load_data;
        else if (tick_en)
            cnt_nxt = cnt_q + W'(1);
        else
            cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (load_wr)
                load_q <= load_data;
        end
    end

endmodule

// File: rtl/sa_alarm.sv
module sa_alarm #(
    parameter int W = secs_alarm_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_adv,
    input  logic [W-1:0] cnt_nxt,
    input  logic         match_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    input  logic         clr_wr,
    output logic [W-1:0] match_q,
    output logic         mask_q,
    output logic         raw_q,
    output logic         irq
);

    logic hit;

    // Equality on the arriving value; a wrapping counter needs no magnitude test.
    assign hit = cnt_adv && (cnt_nxt == match_q);
    assign irq = raw_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            if (match_wr) match_q <= wdata;
            if (mask_wr)  mask_q  <= wdata[0];
            if (hit)
                raw_q <= 1'b1;
            else if (clr_wr)
                raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sa_readmux.sv
module sa_readmux
    import secs_alarm_pkg::*;
#(
    parameter int W = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  reg_sel_e         sel,
    input  logic [ID_IW-1:0] id_idx,
    input  logic [W-1:0]     cnt_q,
    input  logic [W-1:0]     match_q,
    input  logic [W-1:0]     load_q,
    input  logic             mask_q,
    input  logic             raw_q,
    output logic [W-1:0]     rdata_q
);

    logic [W-1:0] rd_val;

    always_comb begin
        case (sel)
            SEL_COUNT: rd_val = cnt_q;
            SEL_MATCH: rd_val = match_q;
            SEL_LOAD:  rd_val = load_q;
            SEL_CTRL:  rd_val = W'(1);
            SEL_MASK:  rd_val = W'(mask_q);
            SEL_RAW:   rd_val = W'(raw_q);
            SEL_MSKD:  rd_val = W'(raw_q & mask_q);
            SEL_ID:    rd_val = W'(id_byte(id_idx));
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= rd_val;
    end

endmodule

// File: rtl/secs_alarm_rtc.sv
module secs_alarm_rtc
    import secs_alarm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    bus_cmd_t      cmd;
    logic          load_wr, match_wr, mask_wr, clr_wr;
    logic [DW-1:0] cnt_q, cnt_nxt, load_q, match_q;
    logic          cnt_adv, mask_q, raw_q;

    always_comb begin
        cmd.wr     = bus_wr;
        cmd.rd     = bus_rd;
        cmd.sel    = decode_sel(bus_addr);
        cmd.id_idx = bus_addr[ID_IW+1:2];
        cmd.wdata  = bus_wdata;
    end

    assign load_wr  = cmd.wr && (cmd.sel == SEL_LOAD);
    assign match_wr = cmd.wr && (cmd.sel == SEL_MATCH);
    assign mask_wr  = cmd.wr && (cmd.sel == SEL_MASK);
    assign clr_wr   = cmd.wr && (cmd.sel == SEL_CLR);

    sa_counter #(.W(DW)) cnt_u (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load_wr   (load_wr),
        .load_data (cmd.wdata),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .cnt_adv   (cnt_adv),
        .load_q    (load_q)
    );

    sa_alarm #(.W(DW)) alm_u (
        .clk      (clk),
        .rst      (rst),
        .cnt_adv  (cnt_adv),
        .cnt_nxt  (cnt_nxt),
        .match_wr (match_wr),
        .mask_wr  (mask_wr),
        .wdata    (cmd.wdata),
        .clr_wr   (clr_wr),
        .match_q  (match_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .irq      (irq_o)
    );

    sa_readmux #(.W(DW)) rmx_u (
        .clk     (clk),
        .rst     (rst),
        .rd      (cmd.rd),
        .sel     (cmd.sel),
        .id_idx  (cmd.id_idx),
        .cnt_q   (cnt_q),
        .match_q (match_q),
        .load_q  (load_q),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .rdata_q (bus_rdata)
    );

endmodule

// File: rtl/secs_alarm_chk.sv
module secs_alarm_chk #(
    parameter int W = secs_alarm_pkg::DW,
    parameter int A = secs_alarm_pkg::AW
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic [A-1:0] bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic         bus_rd,
    input logic [W-1:0] bus_rdata,
    input logic         irq_o,
    input logic [W-1:0] cnt_q,
    input logic         raw_q,
    input logic         mask_q
);

    logic [A-1:0] waddr;
    logic         ld_w, cl_w;
    assign waddr = {bus_addr[A-1:2], 2'b00};
    assign ld_w  = bus_wr && (waddr == A'('h008));
    assign cl_w  = bus_wr && (waddr == A'('h01C));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !raw_q && !irq_o));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !ld_w) |=> cnt_q == $past(cnt_q) + W'(1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !ld_w) |=> $stable(cnt_q));

    // R3
    load_set_chk: assert property (@(posedge clk) disable iff (rst)
        ld_w |=> cnt_q == $past(bus_wdata));

    // R5
    raw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !cl_w) |=> raw_q);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cl_w && !tick_en && !ld_w) |=> !raw_q);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_q |-> !irq_o);

    // R10
    ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && waddr == A'('h00C)) |=> bus_rdata == W'(1));

endmodule

bind secs_alarm_rtc secs_alarm_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cnt_q     (cnt_q),
    .raw_q     (raw_q),
    .mask_q    (mask_q)
);

// File: tb/secs_alarm_rtc_tb_top.sv
module secs_alarm_rtc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    secs_alarm_rtc dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_id(input int i);
        case (i)
            0: return 32'h31; 1: return 32'h10; 2: return 32'h14; 3: return 32'h00;
            4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq_o), 0);
        rd(12'h000, d); chk("R1 count", d, 0);
        rd(12'h004, d); chk("R1 match", d, 0);
        rd(12'h008, d); chk("R1 load", d, 0);
        rd(12'h010, d); chk("R1 mask", d, 0);
        rd(12'h014, d); chk("R1 raw", d, 0);
    endtask

    task automatic t_count_load();
        logic [31:0] d;
        ticks(5);
        rd(12'h000, d); chk("R2 count after 5 ticks", d, 5);
        repeat (3) @(negedge clk);
        rd(12'h000, d); chk("R2 hold without tick", d, 5);
        wr(12'h008, 32'h1000);
        rd(12'h000, d); chk("R3 load sets count", d, 32'h1000);
        rd(12'h008, d); chk("R3 load readback", d, 32'h1000);
        ticks(3);
        rd(12'h000, d); chk("R4 count read", d, 32'h1003);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h2000;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(12'h000, d); chk("R3 load beats tick", d, 32'h2000);
    endtask

    task automatic t_match();
        logic [31:0] d;
        wr(12'h004, 32'h2003);
        rd(12'h004, d); chk("R4 match readback", d, 32'h2003);
        ticks(2);
        rd(12'h014, d); chk("R5 no early raw", d, 0);
        ticks(1);
        chk("R7 irq masked off", 32'(irq_o), 0);
        rd(12'h014, d); chk("R5 raw on match", d, 1);
        rd(12'h018, d); chk("R7 masked read off", d, 0);
        wr(12'h010, 32'h1);
        chk("R7 irq unmasked", 32'(irq_o), 1);
        rd(12'h018, d); chk("R7 masked read on", d, 1);
        ticks(2);
        rd(12'h014, d); chk("R5 raw sticky", d, 1);
        wr(12'h01C, 32'h0);
        chk("R8 irq cleared", 32'(irq_o), 0);
        rd(12'h014, d); chk("R8 raw cleared by zero data", d, 0);
        rd(12'h01C, d); chk("R8 clear reads zero", d, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(12'h008, 32'hFFFF_FFFE);
        wr(12'h004, 32'h1);
        ticks(2);
        rd(12'h000, d); chk("R2 wrap to zero", d, 0);
        rd(12'h014, d); chk("R6 no raw before wrap match", d, 0);
        ticks(1);
        rd(12'h014, d); chk("R6 raw after wrap", d, 1);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(12'h004, 32'h5);
        ticks(3);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(12'h014, d); chk("R9 match beats clear", d, 1);
        wr(12'h01C, 32'h0);
        rd(12'h014, d); chk("R8 clear alone", d, 0);
        wr(12'h008, 32'h5);
        chk("R5 load onto match irq", 32'(irq_o), 1);
        rd(12'h014, d); chk("R5 load onto match raw", d, 1);
        wr(12'h01C, 32'h0);
    endtask

    task automatic t_ctrl_id_undef();
        logic [31:0] d;
        rd(12'h00C, d); chk("R10 ctrl reads one", d, 1);
        wr(12'h00C, 32'h0);
        rd(12'h00C, d); chk("R10 ctrl write ignored", d, 1);
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i * 4), d);
            chk($sformatf("R11 id byte %0d", i), d, exp_id(i));
        end
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, d); chk("R12 undefined reads zero", d, 0);
        rd(12'h004, d); chk("R12 match untouched", d, 32'h5);
        wr(12'h000, 32'h1234);
        rd(12'h000, d); chk("R12 count write ignored", d, 32'h5);
        wr(12'h014, 32'h1);
        rd(12'h014, d); chk("R12 raw write ignored", d, 0);
        wr(12'hFE0, 32'h0);
        rd(12'hFE0, d); chk("R12 id write ignored", d, 32'h31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count_load();
        t_match();
        t_wrap();
        t_race();
        t_ctrl_id_undef();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule